// File: doc/BRIEF.md
# ATA Task-File I/O Address Decoder

This block turns host I/O cycles into register selects for an ATA-style task file. It does not hold the registers. It tells the register bank which one of them a cycle reaches, whether the cycle reads or writes, and how the 16-bit data register's byte lanes line up for that cycle.

A mode input picks one of two decode paths. The I/O path takes a low-byte enable, a high-byte enable and a 10-bit address. It recognises a primary and a secondary task-file base and a primary and a secondary control base. The drive-bus path takes two chip selects, the three low address bits and a DMA acknowledge.

The data register can be reached as one 16-bit word. It can also be reached as two byte cycles at the same offset, in which the first byte is the even half of the word and the second is the odd half. A one-bit pointer inside the block tracks which half comes next. Each clock cycle in which exactly one strobe is low counts as one access.

Top module: `tf_addr_decode`

## Requirements
- R1: In I/O mode (`ide_mode`=0), a cycle with only the low-byte enable active and address bits [9:4] equal to 1Fh or 17h with bit 3 = 0 reads offsets 0..7 as data, error, sector count, sector number, cylinder low, cylinder high, drive/head and status. `reg_sel` bit indices are: data 0, error 1, feature 2, sector count 3, sector number 4, cylinder low 5, cylinder high 6, drive/head 7, status 8, command 9, alternate status 10, device control 11, drive address 12, reserved 13.
- R2: Writes use the same map as reads, except that offset 1 selects feature (bit 2) and offset 7 selects command (bit 9).
- R3: Address bits [9:4] equal to 3Fh or 37h with bits [3:1] = 011b reach the control block. There, offset 6 reads alternate status and writes device control, and offset 7 reads drive address and writes the reserved slot.
- R4: In I/O mode, with both enables active, A0 = 0 and task-file offset 0, the cycle is a word access: it selects data with `lane` = 1 (all 16 bits). Both enables active at any other address is unclaimed.
- R5: With only the low-byte enable active at task-file offset 0, data is selected. Successive such accesses alternate `lane` between 2 (the low lane carries the even byte) and 3 (the low lane carries the odd byte), starting with 2.
- R6: With only the high-byte enable active and A0 = 0, the cycle reaches the register at offset+1. At task-file offset 0 this is error on reads and feature on writes. High-byte-only cycles with A0 = 1 are unclaimed.
- R7: In drive-bus mode (`ide_mode`=1), with chip select 0 active and chip select 1 inactive (and no DMA acknowledge), A2..A0 select the task file as in R1/R2. Offset 0 is a word data access (`lane` = 1).
- R8: In drive-bus mode, with chip select 1 active and chip select 0 inactive, A2..A0 = 110b selects alternate status on reads and device control on writes. Every other offset is unclaimed.
- R9: In drive-bus mode, an active DMA acknowledge with both chip selects inactive selects data as a word (`lane` = 1) whatever the address.
- R10: The byte pointer returns to even on reset, on a word access, and on any valid access that is not a data byte access (including unclaimed ones). It holds across cycles that have no valid strobe.
- R11: When exactly one strobe is low and no decode entry matches, `reg_sel` is zero, `rd_stb`/`wr_stb` are low and `unclaimed` is high. With no strobe low, every output is idle (`unclaimed` low, `lane` 0). `lane` is 0 whenever data is not selected.
- R12: Both strobes low together is invalid. No select, no strobe, `unclaimed` high, and the byte pointer holds.
- R13: I/O addresses outside the four bases, or with bit 3 set at a task-file base, or off offsets 6..7 at a control base, are unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one access per cycle |
| rst_n | input | 1 | Active-low synchronous reset of the byte pointer |
| ide_mode | input | 1 | 0: I/O decoding, 1: drive-bus decoding |
| en_lo_n | input | 1 | Low-byte enable (I/O) / chip select 0 (drive-bus), active low |
| en_hi_n | input | 1 | High-byte enable (I/O) / chip select 1 (drive-bus), active low |
| addr | input | 10 | Host address; drive-bus mode uses bits 2..0 |
| dack_n | input | 1 | DMA acknowledge, active low (drive-bus mode) |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | output | 14 | One-hot register select |
| rd_stb | output | 1 | Claimed read this cycle |
| wr_stb | output | 1 | Claimed write this cycle |
| lane | output | 2 | Data lane control: 0 none, 1 word, 2 even byte, 3 odd byte |
| unclaimed | output | 1 | Valid or conflicting strobe that no entry matched |

## Verification
The decode tables have no state, so a wrong table entry shows in `reg_sel` or `unclaimed` in the same cycle as the faulty access. The only internal state is the even/odd pointer. If it is wrong, nothing shows until the next low-byte-only access to data offset 0, where `lane` reports the wrong half. The bench therefore places byte accesses to data straight after each event that should move or hold the pointer: other registers, word cycles, idle cycles, conflicts, unclaimed cycles and reset. That way a stale or missed update appears within one access.

// File: rtl/tf_dec_pkg.sv
package tf_dec_pkg;

   localparam int NUM_SEL = 14;

   typedef enum logic [3:0] {
      SEL_DATA    = 4'd0,
      SEL_ERROR   = 4'd1,
      SEL_FEATURE = 4'd2,
      SEL_SECCNT  = 4'd3,
      SEL_SECNUM  = 4'd4,
      SEL_CYLLO   = 4'd5,
      SEL_CYLHI   = 4'd6,
      SEL_DRVHEAD = 4'd7,
      SEL_STATUS  = 4'd8,
      SEL_COMMAND = 4'd9,
      SEL_ALTSTAT = 4'd10,
      SEL_DEVCTL  = 4'd11,
      SEL_DRVADDR = 4'd12,
      SEL_RSVD    = 4'd13
   } sel_e;

   typedef enum logic [1:0] {
      LANE_NONE = 2'd0,
      LANE_WORD = 2'd1,
      LANE_EVEN = 2'd2,
      LANE_ODD  = 2'd3
   } lane_e;

   // Result of one decode path: which block, which offset, word or byte.
   typedef struct packed {
      logic       hit;
      logic       ctrl;
      logic [2:0] off;
      logic       word;
   } hit_t;

   function automatic sel_e sel_of(input logic ctrl, input logic [2:0] off,
                                   input logic is_wr);
      sel_e s;
      if (!ctrl) begin
         case (off)
            3'd0:    s = SEL_DATA;
            3'd1:    s = is_wr ? SEL_FEATURE : SEL_ERROR;
            3'd2:    s = SEL_SECCNT;
            3'd3:    s = SEL_SECNUM;
            3'd4:    s = SEL_CYLLO;
            3'd5:    s = SEL_CYLHI;
            3'd6:    s = SEL_DRVHEAD;
            default: s = is_wr ? SEL_COMMAND : SEL_STATUS;
         endcase
      end else if (off == 3'd6) begin
         s = is_wr ? SEL_DEVCTL : SEL_ALTSTAT;
      end else begin
         s = is_wr ? SEL_RSVD : SEL_DRVADDR;
      end
      return s;
   endfunction

endpackage

// File: rtl/tf_io_decode.sv
module tf_io_decode
   import tf_dec_pkg::*;
#(
   parameter int               ADDR_W   = 10,
   parameter logic [ADDR_W-5:0] PRI_TASK = 6'h1F,
   parameter logic [ADDR_W-5:0] SEC_TASK = 6'h17,
   parameter logic [ADDR_W-5:0] PRI_CTRL = 6'h3F,
   parameter logic [ADDR_W-5:0] SEC_CTRL = 6'h37,
   parameter bit               SEC_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_lo_n,
   input  logic              en_hi_n,
   output hit_t              res
);

   localparam int BW = ADDR_W - 4;

   logic [BW-1:0] base;
   logic          task_m;
   logic          ctrl_m;
   logic          both, lo_only, hi_only;

   assign base = addr[ADDR_W-1:4];

   generate
      if (SEC_EN) begin : g_dual
         assign task_m = (base == PRI_TASK) || (base == SEC_TASK);
         assign ctrl_m = (base == PRI_CTRL) || (base == SEC_CTRL);
      end else begin : g_single
         assign task_m = (base == PRI_TASK);
         assign ctrl_m = (base == PRI_CTRL);
      end
   endgenerate

   assign both    = !en_lo_n && !en_hi_n;
   assign lo_only = !en_lo_n &&  en_hi_n;
   assign hi_only =  en_lo_n && !en_hi_n;

   always_comb begin
      res = '0;
      if (task_m && !addr[3]) begin
         if (lo_only) begin
            res.hit = 1'b1;
            res.off = addr[2:0];
         end else if (hi_only && !addr[0]) begin
            res.hit = 1'b1;
            res.off = {addr[2:1], 1'b1};
         end else if (both && addr[2:0] == 3'd0) begin
            res.hit  = 1'b1;
            res.word = 1'b1;
         end
      end else if (ctrl_m && addr[3:1] == 3'b011) begin
         res.ctrl = 1'b1;
         if (lo_only) begin
            res.hit = 1'b1;
            res.off = {2'b11, addr[0]};
         end else if (hi_only && !addr[0]) begin
            res.hit = 1'b1;
            res.off = 3'd7;
         end
      end
   end

endmodule

// File: rtl/tf_ide_decode.sv
module tf_ide_decode
   import tf_dec_pkg::*;
(
   input  logic [2:0] a,
   input  logic       cs0_n,
   input  logic       cs1_n,
   input  logic       dack_n,
   output hit_t       res
);

   always_comb begin
      res = '0;
      if (!dack_n) begin
         if (cs0_n && cs1_n) begin
            res.hit  = 1'b1;
            res.word = 1'b1;
         end
      end else if (!cs0_n && cs1_n) begin
         res.hit  = 1'b1;
         res.off  = a;
         res.word = (a == 3'd0);
      end else if (cs0_n && !cs1_n && a == 3'd6) begin
         res.hit  = 1'b1;
         res.ctrl = 1'b1;
         res.off  = 3'd6;
      end
   end

endmodule

// File: rtl/tf_byte_ptr.sv
module tf_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   input  logic data_byte,
   output logic odd
);

   always_ff @(posedge clk) begin
      if (!rst_n)      odd <= 1'b0;
      else if (access) odd <= data_byte ? ~odd : 1'b0;
   end

endmodule

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
   import tf_dec_pkg::*;
#(
   parameter int               ADDR_W   = 10,
   parameter logic [ADDR_W-5:0] PRI_TASK = 6'h1F,
   parameter logic [ADDR_W-5:0] SEC_TASK = 6'h17,
   parameter logic [ADDR_W-5:0] PRI_CTRL = 6'h3F,
   parameter logic [ADDR_W-5:0] SEC_CTRL = 6'h37,
   parameter bit               SEC_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ide_mode,
   input  logic              en_lo_n,
   input  logic              en_hi_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dack_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic [13:0]       reg_sel,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [1:0]        lane,
   output logic              unclaimed
);

   generate
      if (ADDR_W < 5) begin : g_bad_width
         $error("tf_addr_decode: ADDR_W must be at least 5");
      end
      if (PRI_TASK == PRI_CTRL) begin : g_bad_pri
         $error("tf_addr_decode: primary task and control bases collide");
      end
      if (SEC_EN && (SEC_TASK == PRI_TASK || SEC_CTRL == PRI_CTRL)) begin : g_bad_sec
         $error("tf_addr_decode: secondary base equals primary base");
      end
   endgenerate

   hit_t  io_res, ide_res, res;
   logic  rd_act, wr_act, access, conflict, claimed;
   logic  is_data, data_byte, ptr_odd;
   sel_e  sel;

   tf_io_decode #(
      .ADDR_W  (ADDR_W),
      .PRI_TASK(PRI_TASK),
      .SEC_TASK(SEC_TASK),
      .PRI_CTRL(PRI_CTRL),
      .SEC_CTRL(SEC_CTRL),
      .SEC_EN  (SEC_EN)
   ) u_io (
      .addr   (addr),
      .en_lo_n(en_lo_n),
      .en_hi_n(en_hi_n),
      .res    (io_res)
   );

   tf_ide_decode u_ide (
      .a     (addr[2:0]),
      .cs0_n (en_lo_n),
      .cs1_n (en_hi_n),
      .dack_n(dack_n),
      .res   (ide_res)
   );

   assign res      = ide_mode ? ide_res : io_res;
   assign rd_act   = !rd_n &&  wr_n;
   assign wr_act   =  rd_n && !wr_n;
   assign access   = rd_act || wr_act;
   assign conflict = !rd_n && !wr_n;
   assign claimed  = access && res.hit;

   assign sel       = sel_of(res.ctrl, res.off, wr_act);
   assign is_data   = claimed && !res.ctrl && res.off == 3'd0;
   assign data_byte = is_data && !res.word;

   tf_byte_ptr u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .access   (access),
      .data_byte(data_byte),
      .odd      (ptr_odd)
   );

   always_comb begin
      reg_sel = '0;
      if (claimed) reg_sel = NUM_SEL'(1) << sel;
   end

   always_comb begin
      if (!is_data)      lane = LANE_NONE;
      else if (res.word) lane = LANE_WORD;
      else if (ptr_odd)  lane = LANE_ODD;
      else               lane = LANE_EVEN;
   end

   assign rd_stb    = claimed && rd_act;
   assign wr_stb    = claimed && wr_act;
   assign unclaimed = conflict || (access && !res.hit);

endmodule

// File: rtl/tf_addr_decode_chk.sv
module tf_addr_decode_chk
   import tf_dec_pkg::*;
#(
   parameter int               ADDR_W   = 10,
   parameter logic [ADDR_W-5:0] PRI_TASK = 6'h1F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ide_mode,
   input logic              en_lo_n,
   input logic              en_hi_n,
   input logic [ADDR_W-1:0] addr,
   input logic              dack_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic [13:0]       reg_sel,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [1:0]        lane,
   input logic              unclaimed
);

   logic last_even;

   always_ff @(posedge clk) begin
      if (!rst_n)          last_even <= 1'b0;
      else if (rd_n ^ wr_n) last_even <= (lane == LANE_EVEN);
   end

   // R5
   odd_after_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane == LANE_ODD) |-> last_even);

   // R12
   conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !wr_n) |-> (reg_sel == '0 && !rd_stb && !wr_stb && unclaimed));

   // R11
   unclaimed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unclaimed |-> (reg_sel == '0 && lane == LANE_NONE));

   // R11
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> (rd_n != wr_n && $onehot(reg_sel) && rd_stb == !rd_n));

   // R4
   word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ide_mode && !en_lo_n && !en_hi_n && reg_sel[SEL_DATA]) |-> (lane == LANE_WORD));

   // R9
   dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ide_mode && !dack_n && en_lo_n && en_hi_n && (rd_n != wr_n))
         |-> (reg_sel == (14'd1 << SEL_DATA) && lane == LANE_WORD));

   // R6
   hi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ide_mode && en_lo_n && !en_hi_n && addr[ADDR_W-1:4] == PRI_TASK
         && addr[3:0] == 4'h0 && !rd_n && wr_n) |-> reg_sel[SEL_ERROR]);

endmodule

bind tf_addr_decode tf_addr_decode_chk #(
   .ADDR_W  (ADDR_W),
   .PRI_TASK(PRI_TASK)
) u_chk (.*);

// File: tb/tf_addr_decode_test.sv
module tf_addr_decode_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int S_NONE = -1, S_DATA = 0, S_ERR = 1, S_FEAT = 2, S_SCNT = 3,
                  S_SNUM = 4, S_CLO = 5, S_CHI = 6, S_DH = 7, S_STAT = 8,
                  S_CMD = 9, S_ALT = 10, S_DCTL = 11, S_DADR = 12, S_RSV = 13;
   localparam int L_NONE = 0, L_WORD = 1, L_EVEN = 2, L_ODD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ide_mode = 1'b0, en_lo_n = 1'b1, en_hi_n = 1'b1, dack_n = 1'b1;
   logic       rd_n = 1'b1, wr_n = 1'b1;
   logic [9:0] addr = '0;
   logic [13:0] reg_sel;
   logic       rd_stb, wr_stb, unclaimed;
   logic [1:0] lane;

   typedef struct {
      logic [13:0] sel;
      logic [1:0]  lane;
      logic        rs, ws, unc;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   tf_addr_decode uut (
      .clk(clk), .rst_n(rst_n), .ide_mode(ide_mode), .en_lo_n(en_lo_n),
      .en_hi_n(en_hi_n), .addr(addr), .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n),
      .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb), .lane(lane),
      .unclaimed(unclaimed)
   );

   // driver: one access per clock, expected result pushed to the scoreboard
   task automatic acc(input bit ide, input bit lo_n, input bit hi_n,
                      input logic [9:0] a, input bit dk_n, input bit rn,
                      input bit wn, input int esel, input int elane,
                      input bit eunc, input string tag);
      exp_t e;
      @(negedge clk);
      ide_mode = ide; en_lo_n = lo_n; en_hi_n = hi_n; addr = a;
      dack_n = dk_n; rd_n = rn; wr_n = wn;
      e.sel  = (esel < 0) ? 14'd0 : (14'd1 << esel);
      e.lane = 2'(elane);
      e.rs   = (esel >= 0) && !rn && wn;
      e.ws   = (esel >= 0) && !wn && rn;
      e.unc  = eunc;
      e.tag  = tag;
      q.push_back(e);
   endtask

   task automatic io(input bit lo_n, input bit hi_n, input logic [9:0] a,
                     input bit wr, input int esel, input int elane, input string tag);
      acc(1'b0, lo_n, hi_n, a, 1'b1, wr, !wr, esel, elane, esel < 0, tag);
   endtask

   task automatic ide(input bit cs0_n, input bit cs1_n, input logic [9:0] a,
                      input bit dk_n, input bit wr, input int esel,
                      input int elane, input string tag);
      acc(1'b1, cs0_n, cs1_n, a, dk_n, wr, !wr, esel, elane, esel < 0, tag);
   endtask

   task automatic idle(input string tag);
      acc(1'b0, 1'b1, 1'b1, 10'h1F0, 1'b1, 1'b1, 1'b1, S_NONE, L_NONE, 1'b0, tag);
   endtask

   // monitor: compares outputs mid-cycle, after the driver has settled inputs
   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if (reg_sel !== e.sel || lane !== e.lane || rd_stb !== e.rs ||
             wr_stb !== e.ws || unclaimed !== e.unc) begin
            n_bad++;
            $display("FAIL %s: actual sel=%h lane=%0d rd=%b wr=%b unc=%b expected sel=%h lane=%0d rd=%b wr=%b unc=%b",
                     e.tag, reg_sel, lane, rd_stb, wr_stb, unclaimed,
                     e.sel, e.lane, e.rs, e.ws, e.unc);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL R11 watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle("R10 R11 reset idle outputs");
      @(negedge clk); rst_n = 1'b1;

      // byte pair and pointer behaviour (R5, R10, R12)
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R5 first byte even");
      io(0, 1, 10'h1F0, 0, S_DATA, L_ODD,  "R5 second byte odd");
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R5 third byte restarts even");
      io(0, 1, 10'h1F2, 0, S_SCNT, L_NONE, "R10 other register");
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R10 cleared by other register");
      idle("R11 idle no strobe");
      io(0, 1, 10'h1F0, 0, S_DATA, L_ODD,  "R10 held across idle");
      io(0, 1, 10'h1F0, 1, S_DATA, L_EVEN, "R5 write even byte");
      io(0, 0, 10'h1F0, 0, S_DATA, L_WORD, "R4 word read");
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R10 cleared by word");
      acc(1'b0, 1'b0, 1'b1, 10'h1F0, 1'b1, 1'b0, 1'b0, S_NONE, L_NONE, 1'b1, "R12 strobe conflict");
      io(0, 1, 10'h1F0, 1, S_DATA, L_ODD,  "R12 pointer held over conflict");
      io(0, 1, 10'h170, 0, S_DATA, L_EVEN, "R5 secondary even");
      io(0, 1, 10'h1F8, 0, S_NONE, L_NONE, "R13 A3 set unclaimed");
      io(0, 1, 10'h170, 0, S_DATA, L_EVEN, "R10 cleared by unclaimed");

      // task-file read map (R1)
      io(0, 1, 10'h1F1, 0, S_ERR,  L_NONE, "R1 error");
      io(0, 1, 10'h1F3, 0, S_SNUM, L_NONE, "R1 sector number");
      io(0, 1, 10'h1F4, 0, S_CLO,  L_NONE, "R1 cylinder low");
      io(0, 1, 10'h1F5, 0, S_CHI,  L_NONE, "R1 cylinder high");
      io(0, 1, 10'h1F6, 0, S_DH,   L_NONE, "R1 drive head");
      io(0, 1, 10'h1F7, 0, S_STAT, L_NONE, "R1 status");
      io(0, 1, 10'h171, 0, S_ERR,  L_NONE, "R1 secondary error");
      io(0, 1, 10'h177, 0, S_STAT, L_NONE, "R1 secondary status");

      // write map (R2)
      io(0, 1, 10'h1F1, 1, S_FEAT, L_NONE, "R2 feature");
      io(0, 1, 10'h1F7, 1, S_CMD,  L_NONE, "R2 command");
      io(0, 1, 10'h173, 1, S_SNUM, L_NONE, "R2 secondary sector number");
      io(0, 1, 10'h1F4, 1, S_CLO,  L_NONE, "R2 cylinder low write");

      // control block (R3)
      io(0, 1, 10'h3F6, 0, S_ALT,  L_NONE, "R3 alternate status");
      io(0, 1, 10'h3F6, 1, S_DCTL, L_NONE, "R3 device control");
      io(0, 1, 10'h377, 0, S_DADR, L_NONE, "R3 drive address");
      io(0, 1, 10'h3F7, 1, S_RSV,  L_NONE, "R3 reserved write");
      io(1, 0, 10'h3F6, 0, S_DADR, L_NONE, "R3 R6 high byte at control 6");

      // high-byte-only cycles (R6)
      io(1, 0, 10'h1F0, 0, S_ERR,  L_NONE, "R6 high byte error");
      io(1, 0, 10'h1F0, 1, S_FEAT, L_NONE, "R6 high byte feature");
      io(1, 0, 10'h1F6, 0, S_STAT, L_NONE, "R6 high byte offset 7");
      io(1, 0, 10'h1F1, 0, S_NONE, L_NONE, "R6 high byte odd address");

      // word and base misses (R4, R13)
      io(0, 0, 10'h1F2, 0, S_NONE, L_NONE, "R4 word off data");
      io(0, 0, 10'h1F1, 0, S_NONE, L_NONE, "R4 word odd address");
      io(0, 0, 10'h3F6, 0, S_NONE, L_NONE, "R4 word at control");
      io(0, 1, 10'h2F0, 0, S_NONE, L_NONE, "R13 foreign base");
      io(0, 1, 10'h3F5, 0, S_NONE, L_NONE, "R13 control offset 5");

      // drive-bus mode (R7, R8, R9, R11)
      ide(0, 1, 10'h000, 1, 0, S_DATA, L_WORD, "R7 pio data word");
      ide(0, 1, 10'h3F0, 1, 0, S_DATA, L_WORD, "R7 upper address ignored");
      ide(0, 1, 10'h001, 1, 1, S_FEAT, L_NONE, "R7 feature");
      ide(0, 1, 10'h007, 1, 0, S_STAT, L_NONE, "R7 status");
      ide(0, 1, 10'h007, 1, 1, S_CMD,  L_NONE, "R7 command");
      ide(0, 1, 10'h002, 1, 0, S_SCNT, L_NONE, "R7 sector count");
      ide(1, 0, 10'h006, 1, 0, S_ALT,  L_NONE, "R8 alternate status");
      ide(1, 0, 10'h006, 1, 1, S_DCTL, L_NONE, "R8 device control");
      ide(1, 0, 10'h007, 1, 0, S_NONE, L_NONE, "R8 control offset 7");
      ide(1, 0, 10'h000, 1, 0, S_NONE, L_NONE, "R8 control offset 0");
      ide(1, 1, 10'h005, 0, 0, S_DATA, L_WORD, "R9 dma read");
      ide(1, 1, 10'h3F3, 0, 1, S_DATA, L_WORD, "R9 dma write");
      ide(0, 1, 10'h002, 0, 0, S_NONE, L_NONE, "R9 dma with chip select");
      ide(0, 0, 10'h000, 1, 0, S_NONE, L_NONE, "R11 both chip selects");
      ide(1, 1, 10'h000, 1, 0, S_NONE, L_NONE, "R11 no chip select");

      // reset returns pointer to even (R10)
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R10 even before reset");
      @(negedge clk); rd_n = 1'b1; wr_n = 1'b1; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      io(0, 1, 10'h1F0, 0, S_DATA, L_EVEN, "R10 even after reset");
      idle("R11 final idle");

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule